// File: doc/BRIEF.md
# Frame-Hold Serial Peripheral Master

This block is a serial peripheral master that clocks short frames of a fixed width (four bits by default) out of a small write queue. Each queued word carries a flag marking it as the last one of a transaction. Chip select falls when the first word leaves the queue. It stays low, with the serial clock running frame after frame, until a word carrying the flag has been shifted out completely. This lets a host build a long exchange, such as a four-bit command followed by three four-bit reply frames, out of narrow frames without chip select toggling between them.

Every frame clocked out also shifts one frame in from the peripheral. That frame is pushed into an eight-entry receive queue, widened to 16 bits with the upper bits zero. The half-period divider, the clock polarity variant and the frame width are elaboration-time parameters. The default is mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. If the write queue runs dry before a flagged word arrives, the master waits with chip select still low and the clock idle.

Top module: `spi_frame_hold_master`

## Requirements
- R1: After reset csN is 1, sclk is at its idle level (0 in mode 0), mosi is 0, busy is 0, rxValid is 0, rxOverrun is 0 and txReady is 1.
- R2: Each frame's bits appear on mosi most significant bit first, stable at every rising sclk edge. Bit 3 of txData goes out first, bit 0 last.
- R3: Chip select falls once per transaction and stays low across all consecutive frames. It rises only after a word pushed with txEnd = 1 has been shifted.
- R4: Each frame produces exactly FRAME_W rising sclk edges. sclk rests at its idle level whenever csN is high.
- R5: Each frame pushes one receive entry, built from the bits sampled on miso at the rising edges, first sample in the highest frame bit. Bits 15 down to FRAME_W of the entry are 0.
- R6: csN rises no sooner than DIV_HALF clock cycles after the last falling sclk edge of the end-marked frame.
- R7: When the write queue empties with no end-marked word shifted, csN stays low, busy stays high and sclk stays idle with no edges, until another word is pushed. The transaction then continues.
- R8: A frame that completes while the receive queue holds 8 entries is dropped, and the stored entries are kept. rxOverrun then goes to 1 and stays 1 until reset.
- R9: busy is high from the cycle chip select falls until the cycle it is released, and is high whenever sclk changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txValid | input | 1 | Push a word into the write queue |
| txData | input | FRAME_W | Frame to send, MSB first |
| txEnd | input | 1 | Word closes the transaction |
| txReady | output | 1 | Write queue has room |
| rxValid | output | 1 | Receive queue is not empty |
| rxData | output | 16 | Oldest received frame, zero-padded |
| rxPop | input | 1 | Remove the oldest receive entry |
| rxOverrun | output | 1 | Sticky flag: a received frame was dropped |
| busy | output | 1 | A transaction is in progress |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check on every cycle that chip select is released only from the hold state that follows a flagged word. They also check that the clock never moves while the block is idle, that the overrun flag never clears, and that a full queue never advances its write pointer. Other behaviours can only be shown by the bench's scenarios: the bit order on the wire, the count of clock edges per frame, the contents of the receive queue, and the stall that keeps chip select low. The bench sweeps transaction lengths from one to six frames over several data patterns, runs a stalled transaction and runs an overfilled receive queue. A behavioural slave on the wire records and answers each transaction.

// File: rtl/spi_fh_pkg.sv
package spi_fh_pkg;
  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic pop;     // take the head word of the write queue
    logic load;    // load that word into the transmit shifter
    logic sample;  // capture miso (rising edge)
    logic shift;   // advance the transmit shifter (falling edge)
    logic push;    // frame complete, hand it to the receive queue
  } strobesT;
endpackage

// File: rtl/spi_fh_fifo.sv
module spi_fh_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] wData,
  input  logic         pop,
  output logic [W-1:0] rData,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr[AW-1:0]] <= wData;
  end

  assign rData = mem[rdPtr[AW-1:0]];
  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |=> (wrPtr == $past(wrPtr)));
endmodule

// File: rtl/spi_fh_ctrl.sv
module spi_fh_ctrl
  import spi_fh_pkg::*;
#(
  parameter int FRAME_W  = 4,
  parameter int DIV_HALF = 2,
  parameter bit CPOL     = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    txEmpty,
  input  logic    endFlag,
  output strobesT strb,
  output logic    csN,
  output logic    sclk,
  output logic    busy
);
  localparam int DW = $clog2(DIV_HALF + 1);
  localparam int BW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [DW-1:0] HALF_LAST = DW'(DIV_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_W - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_LOW, ST_HIGH, ST_HOLD} stateT;

  stateT         state, stateNext;
  logic [DW-1:0] divCnt;
  logic [BW-1:0] bitCnt;
  logic          halfDone, lastBit;

  assign halfDone = (divCnt == HALF_LAST);
  assign lastBit  = (bitCnt == BIT_LAST);

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: if (!txEmpty) stateNext = ST_LOAD;
      ST_LOAD: if (halfDone && !txEmpty) begin
        strb.pop  = 1'b1;
        strb.load = 1'b1;
        stateNext = ST_LOW;
      end
      ST_LOW: if (halfDone) begin
        strb.sample = 1'b1;
        stateNext   = ST_HIGH;
      end
      ST_HIGH: if (halfDone) begin
        if (!lastBit) begin
          strb.shift = 1'b1;
          stateNext  = ST_LOW;
        end else begin
          strb.push = 1'b1;
          if (endFlag) stateNext = ST_HOLD;
          else if (!txEmpty) begin
            strb.pop  = 1'b1;
            strb.load = 1'b1;
            stateNext = ST_LOW;
          end else stateNext = ST_LOAD;
        end
      end
      ST_HOLD: if (halfDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state) divCnt <= '0;
      else if (!halfDone)     divCnt <= divCnt + 1'b1;
      if (strb.load)       bitCnt <= '0;
      else if (strb.shift) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign csN  = (state == ST_IDLE);
  assign busy = (state != ST_IDLE);
  assign sclk = (state == ST_HIGH) ? 1'b1 : (state == ST_LOW) ? 1'b0 : CPOL;

  // R3
  hold_needs_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> endFlag);
  // R6
  release_after_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> ($past(state) == ST_HOLD));
endmodule

// File: rtl/spi_fh_datapath.sv
module spi_fh_datapath
  import spi_fh_pkg::*;
#(
  parameter int FRAME_W = 4,
  parameter int RX_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobesT            strb,
  input  logic [FRAME_W-1:0] txWord,
  input  logic               txWordEnd,
  input  logic               miso,
  output logic               mosi,
  output logic               endFlag,
  output logic [RX_W-1:0]    rxWord
);
  logic [FRAME_W-1:0] txShift, rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      endFlag <= 1'b0;
    end else begin
      if (strb.load) begin
        txShift <= txWord;
        endFlag <= txWordEnd;
      end else if (strb.shift) begin
        txShift <= txShift << 1;
      end
      if (strb.sample) rxShift <= {rxShift[FRAME_W-2:0], miso};
    end
  end

  assign mosi   = txShift[FRAME_W-1];
  assign rxWord = {{(RX_W-FRAME_W){1'b0}}, rxShift};

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.shift));
endmodule

// File: rtl/spi_frame_hold_master.sv
module spi_frame_hold_master
  import spi_fh_pkg::*;
#(
  parameter int FRAME_W  = 4,
  parameter int DIV_HALF = 2,
  parameter bit CPOL     = 1'b0,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txValid,
  input  logic [FRAME_W-1:0] txData,
  input  logic               txEnd,
  output logic               txReady,
  output logic               rxValid,
  output logic [15:0]        rxData,
  input  logic               rxPop,
  output logic               rxOverrun,
  output logic               busy,
  output logic               csN,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);
  localparam int RX_W = 16;

  strobesT            strb;
  logic [FRAME_W:0]   txHead;
  logic               txEmpty, txFull, rxEmpty, rxFull, endFlag;
  logic [RX_W-1:0]    rxWord;

  spi_fh_fifo #(.W(FRAME_W + 1), .DEPTH(TX_DEPTH)) txQ (
    .clk(clk), .rstN(rstN), .push(txValid), .wData({txEnd, txData}),
    .pop(strb.pop), .rData(txHead), .empty(txEmpty), .full(txFull));

  spi_fh_ctrl #(.FRAME_W(FRAME_W), .DIV_HALF(DIV_HALF), .CPOL(CPOL)) ctrl (
    .clk(clk), .rstN(rstN), .txEmpty(txEmpty), .endFlag(endFlag),
    .strb(strb), .csN(csN), .sclk(sclk), .busy(busy));

  spi_fh_datapath #(.FRAME_W(FRAME_W), .RX_W(RX_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txWord(txHead[FRAME_W-1:0]),
    .txWordEnd(txHead[FRAME_W]), .miso(miso), .mosi(mosi),
    .endFlag(endFlag), .rxWord(rxWord));

  spi_fh_fifo #(.W(RX_W), .DEPTH(RX_DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .push(strb.push), .wData(rxWord),
    .pop(rxPop), .rData(rxData), .empty(rxEmpty), .full(rxFull));

  always_ff @(posedge clk) begin
    if (!rstN)                     rxOverrun <= 1'b0;
    else if (strb.push && rxFull)  rxOverrun <= 1'b1;
  end

  assign txReady = !txFull;
  assign rxValid = !rxEmpty;

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);
  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxFull));
  // R9
  busy_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> busy);
endmodule

// File: tb/tb_spi_frame_hold_master.sv
module tb_spi_frame_hold_master;
  localparam int FW = 4;
  localparam int DIV_HALF = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic txValid = 1'b0, txEnd = 1'b0, rxPop = 1'b0;
  logic [FW-1:0] txData = '0;
  logic txReady, rxValid, rxOverrun, busy, csN, sclk, mosi, miso;
  logic [15:0] rxData;

  int checks = 0, errors = 0;
  int riseCnt = 0, csFalls = 0, cyc = 0, fallCyc = 0, busyBad = 0;
  logic prevSclk = 1'b0, prevCs = 1'b1;
  logic [63:0] mosiStream = '0;
  logic [31:0] slavePat = '0, slaveSh = '0;

  always #2 clk = ~clk;

  spi_frame_hold_master #(.FRAME_W(FW), .DIV_HALF(DIV_HALF)) dut (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txData(txData), .txEnd(txEnd),
    .txReady(txReady), .rxValid(rxValid), .rxData(rxData), .rxPop(rxPop),
    .rxOverrun(rxOverrun), .busy(busy), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural mode-0 slave
  assign miso = slaveSh[31];
  always @(negedge csN) begin csFalls++; slaveSh = slavePat; end
  always @(negedge sclk) if (!csN) slaveSh = slaveSh << 1;
  always @(posedge sclk) begin riseCnt++; mosiStream = {mosiStream[62:0], mosi}; end

  // cycle monitor: release hold time (R6) and busy tracking (R9)
  always @(negedge clk) begin
    if (rstN) begin
      if (prevSclk && !sclk) fallCyc = cyc;
      if (!prevCs && csN) chk("R6 hold ok", (cyc - fallCyc) >= DIV_HALF, 1);
      if (busy !== !csN) busyBad++;
      if (csN && sclk !== 1'b0) busyBad++;
    end
    prevSclk = sclk; prevCs = csN; cyc++;
  end

  task automatic pushTx(input logic [FW-1:0] d, input logic e);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txValid = 1'b1; txData = d; txEnd = e;
    @(negedge clk);
    txValid = 1'b0; txEnd = 1'b0;
  endtask

  task automatic popRx(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk({req, " valid"}, rxValid, 1);
    chk(req, rxData, exp);
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic waitDone();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic startTxn(input logic [31:0] pat);
    riseCnt = 0; csFalls = 0; mosiStream = '0; slavePat = pat;
  endtask

  function automatic logic [15:0] slice(input logic [31:0] pat, input int k);
    return (k < 8) ? 16'((pat >> (28 - 4 * k)) & 32'hF) : 16'h0;
  endfunction

  initial begin
    #(4 * 150000);
    chk("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] expStream;
    logic [FW-1:0] d;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 csN", csN, 1); chk("R1 sclk", sclk, 0); chk("R1 mosi", mosi, 0);
    chk("R1 busy", busy, 0); chk("R1 rxValid", rxValid, 0);
    chk("R1 overrun", rxOverrun, 0); chk("R1 txReady", txReady, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // sweep of transaction lengths and patterns
    for (int n = 1; n <= 6; n++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] pat;
        pat = 32'hA5C3_0F96 ^ (32'h1357_9BDF * (p + 1)) ^ (32'h0F0F_3C3C * n);
        startTxn(pat);
        expStream = '0;
        for (int i = 0; i < n; i++) begin
          d = FW'((n * 5 + p * 3 + i * 7) & 15);
          expStream = (expStream << FW) | 64'(d);
          pushTx(d, i == n - 1);
        end
        waitDone();
        chk("R3 one chip-select assertion", csFalls, 1);
        chk("R4 clock edges", riseCnt, 4 * n);
        chk("R2 mosi bits", mosiStream, expStream);
        chk("R4 idle clock", sclk, 0);
        chk("R9 busy released", busy, 0);
        chk("R9 busy follows cs", busyBad, 0);
        for (int k = 0; k < n; k++) popRx("R5 rx frame", slice(pat, k));
        chk("R5 rx drained", rxValid, 0);
      end
    end

    // R7 stall without end marker
    startTxn(32'h9E37_79B9);
    pushTx(4'hB, 1'b0);
    pushTx(4'h4, 1'b0);
    repeat (60) @(negedge clk);
    chk("R7 cs held", csN, 0); chk("R7 busy held", busy, 1);
    chk("R7 clock idle", sclk, 0); chk("R7 edges so far", riseCnt, 8);
    repeat (20) @(negedge clk);
    chk("R7 no extra edges", riseCnt, 8);
    pushTx(4'h7, 1'b1);
    waitDone();
    chk("R7 single cs", csFalls, 1); chk("R7 total edges", riseCnt, 12);
    chk("R7 mosi", mosiStream, 64'hB47);
    for (int k = 0; k < 3; k++) popRx("R7 rx frame", slice(32'h9E37_79B9, k));

    // R8 receive overrun
    chk("R8 overrun clear", rxOverrun, 0);
    startTxn(32'h1234_5678);
    for (int i = 0; i < 10; i++) pushTx(FW'(i), i == 9);
    waitDone();
    chk("R8 overrun set", rxOverrun, 1);
    chk("R3 long txn cs", csFalls, 1);
    for (int k = 0; k < 8; k++) popRx("R8 kept frame", slice(32'h1234_5678, k));
    chk("R8 dropped frames", rxValid, 0);
    repeat (5) @(negedge clk);
    chk("R8 overrun sticky", rxOverrun, 1);
    chk("R9 busy follows cs", busyBad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule